// File: doc/BRIEF.md
# Half-Rate ADC Sample Merge and DAC Loopback Path

This block accepts one converter channel that presents two consecutive 12-bit samples per cycle of a half-rate data clock. A full-rate clock, derived by doubling that data clock and therefore edge-aligned with it, takes the held pair one sample at a time. This produces a single 12-bit stream at the sample rate. Each sample is left-justified into a 16-bit word.

The words are written into a small dual-clock FIFO at the full rate. They are read out in the DAC sample-clock domain, which runs at exactly the same frequency but at an arbitrary phase. The result is one 16-bit word per DAC clock toward one DAC channel. Two instances give two independent channels, each converter feeding its own DAC.

A single active-low asynchronous reset holds every domain idle until the clock source reports lock. Two sticky flags report a FIFO that ran dry and a write that was discarded.

Top module: `adc_dac_loopback`

## Requirements
- R1: Of each captured pair, the word built from `smp_first_i` leaves the block before the word built from `smp_second_i`, and pairs leave in capture order.
- R2: Every output word carries its 12-bit sample in bits 15:4, and bits 3:0 are zero.
- R3: In steady operation, every pair captured after reset appears at `dac_word_o`, one new word per `rclk_i` cycle, with none lost or repeated. Neither flag rises.
- R4: Reads begin only once the read side sees at least half the FIFO depth (8 words) stored. Until then, `dac_vld_o` is low and `dac_word_o` is zero.
- R5: Once `dac_vld_o` rises, it stays high until reset.
- R6: When the FIFO is empty on a read cycle after streaming has begun, `dac_word_o` repeats the last word read and `unf_o` rises and stays high until reset.
- R7: A write into a full FIFO is discarded, and the stored words keep their order (the 16 oldest remain). `ovf_o` rises and stays high until reset.
- R8: While `rst_ni` is low, `dac_word_o` is zero, `dac_vld_o`, `ovf_o` and `unf_o` are low, and no sample pair is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk_i | input | 1 | Half-rate data clock; captures a sample pair on each rising edge |
| fclk_i | input | 1 | Full-rate clock, twice `dclk_i`, edge-aligned with it; FIFO write clock |
| rclk_i | input | 1 | DAC sample clock, same frequency as `fclk_i`, arbitrary phase |
| rst_ni | input | 1 | Active-low asynchronous reset for all domains |
| smp_first_i | input | 12 | Earlier sample of the pair |
| smp_second_i | input | 12 | Later sample of the pair |
| dac_word_o | output | 16 | Left-justified word toward the DAC, `rclk_i` domain |
| dac_vld_o | output | 1 | Streaming has started |
| ovf_o | output | 1 | Sticky: a write was discarded, `fclk_i` domain |
| unf_o | output | 1 | Sticky: a read found the FIFO empty, `rclk_i` domain |

## Verification
A swapped merge phase or a lost toggle edge corrupts the word order within two read cycles. This shows as adjacent words exchanged or one sample doubled. A pointer or synchronizer fault shows up within a FIFO turn: either the stream jumps, or a flag fires during what should be steady flow. Priming at the wrong depth is visible at the first valid word, by how many words have already been captured at that point. Faulty overflow handling shows after the read clock resumes: the retained run of 16 words is either not contiguous or not the oldest.

// File: rtl/adc_lb_pkg.sv
`timescale 1ns/1ps
package adc_lb_pkg;
  typedef enum logic {
    RD_PRIME  = 1'b0,
    RD_STREAM = 1'b1
  } rd_state_e;
endpackage

// File: rtl/gray_sync.sv
`timescale 1ns/1ps
module gray_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= g_stg[g-1].q;
    end
  end
  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/hr_pair_merge.sv
`timescale 1ns/1ps
module hr_pair_merge #(
  parameter int SW = 12
) (
  input  logic          dclk_i,
  input  logic          fclk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] first_i,
  input  logic [SW-1:0] second_i,
  output logic [SW-1:0] smp_o,
  output logic          vld_o
);
  logic [SW-1:0] pair_a_q, pair_b_q;
  logic          tog_q;

  // half-rate capture; toggle marks each new pair for the full-rate side
  always_ff @(posedge dclk_i or negedge rst_ni)
    if (!rst_ni) begin
      pair_a_q <= '0;
      pair_b_q <= '0;
      tog_q    <= 1'b0;
    end else begin
      pair_a_q <= first_i;
      pair_b_q <= second_i;
      tog_q    <= ~tog_q;
    end

  logic          seen_q, vld_q;
  logic [SW-1:0] hold_q, smp_q;

  // clocks are edge-aligned, so pair regs are stable when sampled here
  always_ff @(posedge fclk_i or negedge rst_ni)
    if (!rst_ni) begin
      seen_q <= 1'b0;
      hold_q <= '0;
      smp_q  <= '0;
      vld_q  <= 1'b0;
    end else if (tog_q != seen_q) begin
      seen_q <= tog_q;
      smp_q  <= pair_a_q;
      hold_q <= pair_b_q;
      vld_q  <= 1'b1;
    end else begin
      smp_q  <= hold_q;
    end

  assign smp_o = smp_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/cdc_word_fifo.sv
`timescale 1ns/1ps
module cdc_word_fifo
  import adc_lb_pkg::*;
#(
  parameter int WW    = 16,
  parameter int DEPTH = 16,  // power of two, >= 4
  parameter int SYNC  = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [WW-1:0] wr_data_i,
  output logic          ovf_o,
  output logic [WW-1:0] rd_data_o,
  output logic          rd_vld_o,
  output logic          unf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] START_FILL = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WW-1:0] mem_q [DEPTH];

  // write domain
  logic [PW-1:0] wbin_q, wgray_q, rgray_w, wbin_nxt;
  logic          full, ovf_q;

  assign wbin_nxt = wbin_q + 1'b1;
  assign full     = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

  always_ff @(posedge wclk_i or negedge rst_ni)
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (full) ovf_q <= 1'b1;
      else begin
        wbin_q  <= wbin_nxt;
        wgray_q <= bin2gray(wbin_nxt);
      end
    end

  always_ff @(posedge wclk_i)
    if (wr_en_i && !full) mem_q[wbin_q[AW-1:0]] <= wr_data_i;

  gray_sync #(.W(PW), .STAGES(SYNC)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray_q),
    .q_o   (rgray_w)
  );

  // read domain
  logic [PW-1:0] rbin_q, rgray_q, wgray_r, wbin_r, rbin_nxt, fill;
  logic          empty, go, vld_q, unf_q;
  logic [WW-1:0] data_q;
  rd_state_e     state_q;

  gray_sync #(.W(PW), .STAGES(SYNC)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray_q),
    .q_o   (wgray_r)
  );

  assign wbin_r   = gray2bin(wgray_r);
  assign fill     = wbin_r - rbin_q;
  assign empty    = (fill == '0);
  assign rbin_nxt = rbin_q + 1'b1;
  assign go       = (state_q == RD_STREAM) || (fill >= START_FILL);

  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= RD_PRIME;
      rbin_q  <= '0;
      rgray_q <= '0;
      data_q  <= '0;
      vld_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else if (go) begin
      state_q <= RD_STREAM;
      vld_q   <= 1'b1;
      if (!empty) begin
        data_q  <= mem_q[rbin_q[AW-1:0]];
        rbin_q  <= rbin_nxt;
        rgray_q <= bin2gray(rbin_nxt);
      end else begin
        unf_q   <= 1'b1;  // hold data_q
      end
    end

  assign ovf_o     = ovf_q;
  assign rd_data_o = data_q;
  assign rd_vld_o  = vld_q;
  assign unf_o     = unf_q;
endmodule

// File: rtl/adc_dac_loopback.sv
`timescale 1ns/1ps
module adc_dac_loopback
  import adc_lb_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int WORD_W      = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                dclk_i,
  input  logic                fclk_i,
  input  logic                rclk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] smp_first_i,
  input  logic [SAMPLE_W-1:0] smp_second_i,
  output logic [WORD_W-1:0]   dac_word_o,
  output logic                dac_vld_o,
  output logic                ovf_o,
  output logic                unf_o
);
  localparam int PAD_W = WORD_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] smp;
  logic                smp_vld;
  logic [WORD_W-1:0]   word;

  hr_pair_merge #(.SW(SAMPLE_W)) u_merge (
    .dclk_i  (dclk_i),
    .fclk_i  (fclk_i),
    .rst_ni  (rst_ni),
    .first_i (smp_first_i),
    .second_i(smp_second_i),
    .smp_o   (smp),
    .vld_o   (smp_vld)
  );

  if (PAD_W > 0) begin : g_pad
    assign word = {smp, {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign word = smp;
  end

  cdc_word_fifo #(.WW(WORD_W), .DEPTH(FIFO_DEPTH), .SYNC(SYNC_STAGES)) u_fifo (
    .wclk_i   (fclk_i),
    .rclk_i   (rclk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (smp_vld),
    .wr_data_i(word),
    .ovf_o    (ovf_o),
    .rd_data_o(dac_word_o),
    .rd_vld_o (dac_vld_o),
    .unf_o    (unf_o)
  );
endmodule

// File: rtl/adc_dac_loopback_chk.sv
`timescale 1ns/1ps
module adc_dac_loopback_chk #(
  parameter int WW    = 16,
  parameter int PAD_W = 4
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic [WW-1:0] word_i,
  input logic          vld_i,
  input logic          unf_i,
  input logic          ovf_i
);
  p_vld_sticky_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    vld_i |=> vld_i);

  p_unf_sticky_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    unf_i |=> unf_i);

  p_hold_on_unf_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(unf_i) |-> $stable(word_i));

  p_low_pad_zero_r2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    vld_i |-> (word_i[PAD_W-1:0] == '0));

  p_idle_before_prime_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !vld_i |-> (word_i == '0 && !unf_i));

  p_ovf_sticky_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);
endmodule

bind adc_dac_loopback adc_dac_loopback_chk #(
  .WW   (WORD_W),
  .PAD_W(WORD_W - SAMPLE_W)
) u_chk (
  .wclk_i(fclk_i),
  .rclk_i(rclk_i),
  .rst_ni(rst_ni),
  .word_i(dac_word_o),
  .vld_i (dac_vld_o),
  .unf_i (unf_o),
  .ovf_i (ovf_o)
);

// File: tb/adc_dac_loopback_bench.sv
`timescale 1ns/1ps
module adc_dac_loopback_bench;
  logic        dclk = 1'b0, fclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  bit          wr_run = 1'b1, rd_run = 1'b1;
  logic [11:0] smp_first = '0, smp_second = '0;
  logic [15:0] dac_word;
  logic        dac_vld, ovf, unf;

  int          checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_word = '0;
  int          cmp_left = -1;
  int          pair_cnt = 0;
  bit          seen_vld = 1'b0;

  adc_dac_loopback u_adc_dac_loopback (
    .dclk_i      (dclk),
    .fclk_i      (fclk),
    .rclk_i      (rclk),
    .rst_ni      (rst_ni),
    .smp_first_i (smp_first),
    .smp_second_i(smp_second),
    .dac_word_o  (dac_word),
    .dac_vld_o   (dac_vld),
    .ovf_o       (ovf),
    .unf_o       (unf)
  );

  // 250 MHz write clock, half-rate data clock aligned to it
  initial forever begin
    #2;
    if (wr_run) begin
      fclk = ~fclk;
      if (fclk) dclk = ~dclk;
    end
  end

  // same frequency, shifted phase
  initial begin
    #1.3;
    forever begin
      #2;
      if (rd_run) rclk = ~rclk;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // sample pairs, mode changes every 64 pairs
  always @(negedge dclk) begin : drv
    logic [11:0] a, b;
    if (rst_ni) begin
      case ((pair_cnt / 64) % 4)
        0: begin a = 12'(pair_cnt * 2); b = 12'(pair_cnt * 2 + 1); end
        1: begin a = pair_cnt[0] ? 12'h001 : 12'hFFF; b = pair_cnt[0] ? 12'h800 : 12'h000; end
        2: begin a = 12'($urandom); b = 12'($urandom); end
        default: begin a = 12'hFFF - 12'(pair_cnt); b = 12'(pair_cnt); end
      endcase
      smp_first  = a;
      smp_second = b;
      exp_q.push_back({a, 4'h0});
      exp_q.push_back({b, 4'h0});
      pair_cnt++;
    end
  end

  // reference comparison on every read clock
  always @(posedge rclk) begin : mon
    logic [15:0] e;
    #1;
    if (rst_ni && dac_vld) begin
      if (!seen_vld) begin
        seen_vld = 1'b1;
        chk(exp_q.size() >= 8, "R4 words captured at first read", exp_q.size(), 8);
      end
      if (!unf && cmp_left != 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 output without captured pair", dac_word, 0);
        else begin
          e = exp_q.pop_front();
          chk(dac_word == e, "R1 R2 R3 stream word", dac_word, e);
          last_word = dac_word;
          if (cmp_left > 0) cmp_left--;
        end
      end
    end
  end

  initial begin
    #150000;
    chk(1'b0, "R3 watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] w;
    #10;
    chk(dac_word == 0 && !dac_vld && !ovf && !unf, "R8 reset idle", {dac_vld, ovf, unf, dac_word}, 0);
    @(posedge dclk); #1 rst_ni = 1'b1;
    repeat (4) @(posedge rclk);
    #1 chk(!dac_vld, "R4 no read before prime", dac_vld, 0);

    wait (seen_vld);
    repeat (700) @(posedge rclk);
    #1 chk(!ovf && !unf, "R3 no flags in steady flow", {ovf, unf}, 0);
    chk(dac_vld, "R5 valid held", dac_vld, 1);

    // underflow: stop the write side
    @(posedge dclk); #1 wr_run = 1'b0;
    repeat (40) @(posedge rclk);
    #1 chk(unf, "R6 underflow flag", unf, 1);
    chk(dac_word == last_word, "R6 repeats last word", dac_word, last_word);
    w = dac_word;
    repeat (5) @(posedge rclk);
    #1 chk(dac_word == w, "R6 word stable while empty", dac_word, w);
    chk(unf, "R6 flag sticky", unf, 1);
    chk(dac_vld, "R5 valid held in underflow", dac_vld, 1);

    // reset clears everything
    rst_ni = 1'b0;
    exp_q.delete();
    seen_vld = 1'b0;
    #1 chk(dac_word == 0 && !dac_vld && !ovf && !unf, "R8 reset clears", {dac_vld, ovf, unf, dac_word}, 0);
    wr_run = 1'b1;
    #20;
    chk(exp_q.size() == 0, "R8 no capture in reset", exp_q.size(), 0);
    @(posedge dclk); #1 rst_ni = 1'b1;

    wait (seen_vld);
    repeat (50) @(posedge rclk);
    #1 chk(!ovf, "R3 no overflow after restart", ovf, 0);

    // overflow: stop the read side
    rd_run = 1'b0;
    #200;
    chk(ovf, "R7 overflow flag", ovf, 1);
    chk(!unf, "R7 no underflow", unf, 0);
    cmp_left = 16;
    rd_run = 1'b1;
    repeat (30) @(posedge rclk);
    #1 chk(cmp_left == 0, "R7 sixteen oldest words retained", cmp_left, 0);
    chk(ovf, "R7 flag sticky", ovf, 1);
    finish_run();
  end
endmodule